// File: doc/BRIEF.md
# Charger Interrupt and Flag Controller

This block gathers charger events into latched interrupt registers and signals them to a host processor on one flag output. It watches a 3-bit charge-state code from an external charge sequencer, one status event group and three fault event groups, and it has a small register port for reads and writes. Each event bit latches on a rising or a falling edge of its raw signal, chosen per bit. Any change of the charge-state code latches a dedicated status bit.

The flag output rests at a level set by the charge state. It is low while charging or waiting and high otherwise. An event drives a fixed-length pulse at the opposite level. Per-bit masks and one global mask decide which latched bits may request a pulse. After one pulse, no other pulse is issued until the host has read every interrupt register back to zero. A summary register gives the live state, the battery-switch presence and two roll-up bits, so one read shows which group needs attention.

Top module: `chg_irq_flag`

## Requirements
- R1: With no pulse in progress, `flag_o` is low when bit `chg_state_i` of `ACTIVE_MASK` is 1 (default states 1 to 4) and high otherwise. It follows the state input with no register delay.
- R2: An unmasked event whose raw edge is sampled at clock edge N inverts `flag_o` from its idle level for exactly `PULSE_CYC` cycles (default 16), starting after edge N+1.
- R3: Edge-select registers at addresses 9 to 12 (status, fault A, fault B, fault C) reset to 0xFF. Bit value 1 latches the matching event bit on a rising edge and 0 latches it on a falling edge. The other edge has no effect.
- R4: Mask registers at addresses 5 to 8 (same group order) reset to 0x00. A set mask bit stops its interrupt bit from requesting a pulse, but the bit still latches.
- R5: Bit 0 of the control register at address 13 (reset 0) suppresses every pulse. Latching is not affected.
- R6: Interrupt registers are at address 1 (status), 2 (fault A), 3 (fault B) and 4 (fault C). A read returns the contents held before the read on `rdata_o` after the read edge and clears the register.
- R7: If a raw edge arrives in the cycle its register is read, the read returns the old contents and the new bit stays latched for the next read.
- R8: After a pulse starts, no further pulse is issued until all four interrupt registers have been zero. Once they have, a new pending event fires again.
- R9: The summary register at address 0 is not cleared by a read. Bits [2:0] hold the live state, bit 3 holds `bsw_present_i`, bit 6 is set if any status bit is pending, bit 7 is set if any fault bit is pending, and bits [5:4] read 0.
- R10: A change of `chg_state_i` latches status interrupt bit 0. Raw status inputs map to status bits [7:1].
- R11: Mask, edge-select and control registers read back the last value written. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chg_state_i | input | 3 | Charge-state code from the sequencer |
| bsw_present_i | input | 1 | Battery switch detected |
| stat_evt_i | input | 7 | Raw status events (status bits 7:1) |
| fa_evt_i | input | 8 | Raw fault group A events |
| fb_evt_i | input | 8 | Raw fault group B events |
| fc_evt_i | input | 8 | Raw fault group C events |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| flag_o | output | 1 | Interrupt and status flag |

## Verification
The idle level of the flag is combinational on the state input, so the bench checks it one settle delay after it changes the state. An event edge needs one clock edge to latch and a second to start the pulse. The bench therefore checks that the flag has not yet moved after the first edge, that it is inverted after the second, that it is still inverted `PULSE_CYC`-1 edges later, and that it is back at idle one edge after that. Read data is registered at the read edge and is sampled just after it. Each "no pulse" case is checked two edges after its stimulus, which is the first cycle a pulse could show.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;
    localparam int REG_W   = 8;
    localparam int STATE_W = 3;
    localparam int STATE_N = 1 << STATE_W;
    localparam int ADDR_W  = 4;
    localparam int NGRP    = 4;

    // address layout
    localparam int SUM_ADDR  = 0;
    localparam int INT_BASE  = 1;
    localparam int MSK_BASE  = INT_BASE + NGRP;
    localparam int EDG_BASE  = MSK_BASE + NGRP;
    localparam int CTRL_ADDR = EDG_BASE + NGRP;

    // summary bit positions
    localparam int SUM_BSW   = 3;
    localparam int SUM_STAT  = 6;
    localparam int SUM_FAULT = 7;

    typedef logic [NGRP-1:0][REG_W-1:0] grp_vec_t;
endpackage

// File: rtl/chg_evt_latch.sv
module chg_evt_latch
    import chg_irq_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    input  logic [W-1:0] rise_sel_i,
    input  logic [W-1:0] ext_set_i,
    input  logic         clr_i,
    output logic [W-1:0] pend_o
);
    typedef struct packed {
        logic [W-1:0] raw_prev;
        logic [W-1:0] pend;
    } lat_t;

    lat_t st_d, st_q;

    always_comb begin
        logic [W-1:0] hit;
        hit = (raw_i & ~st_q.raw_prev & rise_sel_i)
            | (~raw_i & st_q.raw_prev & ~rise_sel_i);
        st_d          = st_q;
        st_d.raw_prev = raw_i;
        // set wins over a clear in the same cycle
        st_d.pend     = (clr_i ? '0 : st_q.pend) | hit | ext_set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/chg_regs.sv
module chg_regs
    import chg_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  grp_vec_t          pend_i,
    input  logic [REG_W-1:0]  summary_i,
    output grp_vec_t          mask_o,
    output grp_vec_t          rise_o,
    output logic              gmask_o,
    output logic [NGRP-1:0]   clr_o,
    output logic [REG_W-1:0]  rdata_o
);
    typedef struct packed {
        grp_vec_t         mask;
        grp_vec_t         rise;
        logic             gmask;
        logic [REG_W-1:0] rdata;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        int a;
        a     = int'(addr_i);
        st_d  = st_q;
        clr_o = '0;
        if (rd_en_i) begin
            st_d.rdata = '0;
            if (a == SUM_ADDR)  st_d.rdata = summary_i;
            if (a == CTRL_ADDR) st_d.rdata = {{(REG_W-1){1'b0}}, st_q.gmask};
            for (int g = 0; g < NGRP; g++) begin
                if (a == INT_BASE + g) begin
                    st_d.rdata = pend_i[g];
                    clr_o[g]   = 1'b1;
                end
                if (a == MSK_BASE + g) st_d.rdata = st_q.mask[g];
                if (a == EDG_BASE + g) st_d.rdata = st_q.rise[g];
            end
        end
        if (wr_en_i) begin
            if (a == CTRL_ADDR) st_d.gmask = wdata_i[0];
            for (int g = 0; g < NGRP; g++) begin
                if (a == MSK_BASE + g) st_d.mask[g] = wdata_i;
                if (a == EDG_BASE + g) st_d.rise[g] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask  <= '0;
            st_q.rise  <= '1;
            st_q.gmask <= 1'b0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o  = st_q.mask;
    assign rise_o  = st_q.rise;
    assign gmask_o = st_q.gmask;
    assign rdata_o = st_q.rdata;
endmodule

// File: rtl/chg_flag_pulse.sv
module chg_flag_pulse #(
    parameter int PULSE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic all_clear_i,
    output logic busy_o,
    output logic armed_o
);
    localparam int CNT_W = $clog2(PULSE_CYC + 1);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } pls_t;

    pls_t st_d, st_q;

    always_comb begin
        logic fire;
        fire = st_q.armed && req_i && (st_q.cnt == '0);
        st_d = st_q;
        if (fire)                 st_d.cnt = CNT_W'(PULSE_CYC);
        else if (st_q.cnt != '0)  st_d.cnt = st_q.cnt - 1'b1;
        if (fire)                 st_d.armed = 1'b0;
        else if (all_clear_i)     st_d.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.armed <= 1'b1;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o  = (st_q.cnt != '0);
    assign armed_o = st_q.armed;
endmodule

// File: rtl/chg_irq_flag.sv
module chg_irq_flag
    import chg_irq_pkg::*;
#(
    parameter int                 PULSE_CYC   = 16,
    parameter logic [STATE_N-1:0] ACTIVE_MASK = 8'b0001_1110
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STATE_W-1:0] chg_state_i,
    input  logic               bsw_present_i,
    input  logic [REG_W-2:0]   stat_evt_i,
    input  logic [REG_W-1:0]   fa_evt_i,
    input  logic [REG_W-1:0]   fb_evt_i,
    input  logic [REG_W-1:0]   fc_evt_i,
    input  logic               rd_en_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [REG_W-1:0]   wdata_i,
    output logic [REG_W-1:0]   rdata_o,
    output logic               flag_o
);
    typedef struct packed {
        logic [STATE_W-1:0] state_prev;
    } top_t;

    top_t st_d, st_q;

    grp_vec_t          raw_vec, ext_vec, pend, mask, rise;
    logic [NGRP-1:0]   clr;
    logic [REG_W-1:0]  summary;
    logic              gmask, req_any, all_clear, pulse_busy, pulse_armed;
    logic              state_chg;

    always_comb begin
        st_d            = st_q;
        st_d.state_prev = chg_state_i;
        state_chg       = (chg_state_i != st_q.state_prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        raw_vec    = '0;
        ext_vec    = '0;
        raw_vec[0] = {stat_evt_i, 1'b0};
        raw_vec[1] = fa_evt_i;
        raw_vec[2] = fb_evt_i;
        raw_vec[3] = fc_evt_i;
        ext_vec[0] = {{(REG_W-1){1'b0}}, state_chg};
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        chg_evt_latch #(.W(REG_W)) u_latch (
            .clk        (clk),
            .rst_n      (rst_n),
            .raw_i      (raw_vec[g]),
            .rise_sel_i (rise[g]),
            .ext_set_i  (ext_vec[g]),
            .clr_i      (clr[g]),
            .pend_o     (pend[g])
        );
    end

    always_comb begin
        logic fault_any;
        fault_any = 1'b0;
        req_any   = 1'b0;
        all_clear = 1'b1;
        for (int g = 0; g < NGRP; g++) begin
            req_any   = req_any | (|(pend[g] & ~mask[g]));
            all_clear = all_clear & (pend[g] == '0);
            if (g > 0) fault_any = fault_any | (|pend[g]);
        end
        req_any              = req_any & ~gmask;
        summary              = '0;
        summary[STATE_W-1:0] = chg_state_i;
        summary[SUM_BSW]     = bsw_present_i;
        summary[SUM_STAT]    = |pend[0];
        summary[SUM_FAULT]   = fault_any;
    end

    chg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en_i),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .pend_i    (pend),
        .summary_i (summary),
        .mask_o    (mask),
        .rise_o    (rise),
        .gmask_o   (gmask),
        .clr_o     (clr),
        .rdata_o   (rdata_o)
    );

    chg_flag_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_any),
        .all_clear_i (all_clear),
        .busy_o      (pulse_busy),
        .armed_o     (pulse_armed)
    );

    // idle level high outside active/wait states; pulse inverts it
    assign flag_o = ~ACTIVE_MASK[chg_state_i] ^ pulse_busy;
endmodule

// File: rtl/chg_irq_flag_chk.sv
module chg_irq_flag_chk
    import chg_irq_pkg::*;
#(
    parameter logic [STATE_N-1:0] ACTIVE_MASK = 8'b0001_1110
) (
    input logic               clk,
    input logic               rst_n,
    input logic [STATE_W-1:0] chg_state_i,
    input logic               flag_o,
    input logic               rd_en_i,
    input logic [ADDR_W-1:0]  addr_i,
    input logic [STATE_W-1:0] rd_state,
    input logic               busy,
    input logic               armed,
    input logic               gmask,
    input logic               req_any
);
    AST_FLAG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (flag_o == !ACTIVE_MASK[chg_state_i])); // R1

    AST_FLAG_PULSE_POL: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (flag_o == ACTIVE_MASK[chg_state_i])); // R2

    AST_PULSE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_any)); // R4

    AST_GMASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (gmask && !busy) |=> !busy); // R5

    AST_ONE_PULSE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(armed)); // R8

    AST_SUMMARY_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en_i && (addr_i == ADDR_W'(SUM_ADDR))) |-> (rd_state == $past(chg_state_i))); // R9
endmodule

bind chg_irq_flag chg_irq_flag_chk #(.ACTIVE_MASK(ACTIVE_MASK)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chg_state_i (chg_state_i),
    .flag_o      (flag_o),
    .rd_en_i     (rd_en_i),
    .addr_i      (addr_i),
    .rd_state    (rdata_o[2:0]),
    .busy        (pulse_busy),
    .armed       (pulse_armed),
    .gmask       (gmask),
    .req_any     (req_any)
);

// File: tb/tb_chg_irq_flag.sv
module tb_chg_irq_flag;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] chg_state_i;
    logic       bsw_present_i;
    logic [6:0] stat_evt_i;
    logic [7:0] fa_evt_i, fb_evt_i, fc_evt_i;
    logic       rd_en_i, wr_en_i;
    logic [3:0] addr_i;
    logic [7:0] wdata_i;
    logic [7:0] rdata_o;
    logic       flag_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] rv;

    always #2 clk = ~clk;   // 250 MHz

    chg_irq_flag dut (.*);

    // {state[2:0], expected idle flag} -- gmask held so no pulse
    localparam logic [3:0] VEC [8] = '{
        {3'd1, 1'b0}, {3'd2, 1'b0}, {3'd3, 1'b0}, {3'd4, 1'b0},
        {3'd5, 1'b1}, {3'd6, 1'b1}, {3'd7, 1'b1}, {3'd0, 1'b1}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        addr_i = a; rd_en_i = 1'b1;
        tick();
        rd_en_i = 1'b0;
        d = rdata_o;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        tick();
        wr_en_i = 1'b0;
    endtask

    task automatic clear_all();
        logic [7:0] t;
        for (int a = 1; a <= 4; a++) rd(4'(a), t);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; chg_state_i = '0; bsw_present_i = 1'b0;
        stat_evt_i = '0; fa_evt_i = '0; fb_evt_i = '0; fc_evt_i = '0;
        rd_en_i = 1'b0; wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
        tick(3);
        rst_n = 1'b1;
        tick();

        // reset state
        chk("R1 reset idle", {7'd0, flag_o}, 8'd1);
        rd(4'd0, rv);  chk("R9 reset summary", rv, 8'h00);
        rd(4'd6, rv);  chk("R4 reset mask", rv, 8'h00);
        rd(4'd10, rv); chk("R3 reset edge", rv, 8'hFF);
        rd(4'd13, rv); chk("R5 reset ctrl", rv, 8'h00);
        rd(4'd15, rv); chk("R11 unmapped", rv, 8'h00);

        // idle level table walk
        wr(4'd13, 8'h01);
        foreach (VEC[i]) begin
            chg_state_i = VEC[i][3:1];
            tick();
            chk("R1 idle level", {7'd0, flag_o}, {7'd0, VEC[i][0]});
            rd(4'd0, rv);
            chk("R9 summary state", rv & 8'h47, 8'h40 | {5'd0, VEC[i][3:1]});
        end
        clear_all();
        rd(4'd0, rv); chk("R9 summary cleared", rv, 8'h00);

        // pulse width and polarity, state 2 (idle low)
        chg_state_i = 3'd2; tick(); clear_all(); wr(4'd13, 8'h00);
        fa_evt_i[2] = 1'b1;
        tick(); chk("R2 not yet", {7'd0, flag_o}, 8'd0);
        tick(); chk("R2 pulse start", {7'd0, flag_o}, 8'd1);
        tick(15); chk("R2 pulse last", {7'd0, flag_o}, 8'd1);
        tick(); chk("R2 pulse end", {7'd0, flag_o}, 8'd0);
        rd(4'd0, rv); chk("R9 faultint", rv, 8'h82);
        rd(4'd2, rv); chk("R6 read fa", rv, 8'h04);
        rd(4'd2, rv); chk("R6 cleared", rv, 8'h00);
        fa_evt_i[2] = 1'b0; tick();
        rd(4'd2, rv); chk("R3 falling ignored", rv, 8'h00);

        // one pulse until all clear
        stat_evt_i[0] = 1'b1; fb_evt_i[0] = 1'b1;
        tick(2); chk("R8 first pulse", {7'd0, flag_o}, 8'd1);
        tick(16); chk("R8 first done", {7'd0, flag_o}, 8'd0);
        rd(4'd3, rv); chk("R6 read fb", rv, 8'h01);
        fc_evt_i[0] = 1'b1;
        tick(2); chk("R8 no repulse", {7'd0, flag_o}, 8'd0);
        tick(3); chk("R8 still none", {7'd0, flag_o}, 8'd0);
        rd(4'd1, rv); chk("R10 stat raw bit1", rv, 8'h02);
        rd(4'd4, rv); chk("R6 read fc", rv, 8'h01);
        fc_evt_i[0] = 1'b0; fb_evt_i[1] = 1'b1;
        tick(2); chk("R8 rearmed", {7'd0, flag_o}, 8'd1);
        tick(17);
        stat_evt_i = '0; fb_evt_i = '0;
        clear_all();

        // per-bit mask
        wr(4'd6, 8'h02);
        fa_evt_i[1] = 1'b1;
        tick(2); chk("R4 masked no pulse", {7'd0, flag_o}, 8'd0);
        rd(4'd2, rv); chk("R4 still latched", rv, 8'h02);
        rd(4'd6, rv); chk("R11 mask readback", rv, 8'h02);
        fa_evt_i = '0; wr(4'd6, 8'h00);

        // falling-edge select
        wr(4'd12, 8'hFE);
        fc_evt_i[0] = 1'b1; tick();
        rd(4'd4, rv); chk("R3 rise ignored", rv, 8'h00);
        fc_evt_i[0] = 1'b0;
        tick(2); chk("R3 fall pulse", {7'd0, flag_o}, 8'd1);
        rd(4'd4, rv); chk("R3 fall latched", rv, 8'h01);
        tick(16); wr(4'd12, 8'hFF);

        // set wins over clear
        fb_evt_i[3] = 1'b1; addr_i = 4'd3; rd_en_i = 1'b1;
        tick(); rd_en_i = 1'b0;
        chk("R7 read old", rdata_o, 8'h00);
        rd(4'd3, rv); chk("R7 bit kept", rv, 8'h08);
        tick(18); fb_evt_i = '0; clear_all();

        // global mask
        wr(4'd13, 8'h01);
        fa_evt_i[5] = 1'b1;
        tick(2); chk("R5 gmask no pulse", {7'd0, flag_o}, 8'd0);
        rd(4'd0, rv); chk("R5 summary pending", rv, 8'h82);
        rd(4'd2, rv); chk("R5 latched", rv, 8'h20);
        fa_evt_i = '0;

        // idle high state, pulse goes low
        chg_state_i = 3'd6; tick(); clear_all(); wr(4'd13, 8'h00);
        chk("R1 idle high", {7'd0, flag_o}, 8'd1);
        fc_evt_i[4] = 1'b1;
        tick(2); chk("R2 low pulse", {7'd0, flag_o}, 8'd0);
        tick(17); chk("R2 back high", {7'd0, flag_o}, 8'd1);
        fc_evt_i = '0; clear_all();

        // state change interrupt
        chg_state_i = 3'd5;
        tick(2); chk("R10 state pulse", {7'd0, flag_o}, 8'd0);
        rd(4'd1, rv); chk("R10 state bit", rv, 8'h01);
        tick(18);

        // readback and summary bits
        wr(4'd8, 8'hA5);
        rd(4'd8, rv); chk("R11 readback", rv, 8'hA5);
        bsw_present_i = 1'b1;
        rd(4'd0, rv); chk("R9 bsw bit", rv, 8'h0D);

        finish_run();
    end
endmodule